// File: doc/BRIEF.md
# Flash Sector Erase Sequencer

This controller runs the whole command exchange needed to erase one sector of a NOR flash that uses the common unlock-and-command protocol. A single start pulse carries the sector's word address. The block then issues the fixed chain of command writes and polls the device status. It stops when the device reports ready, or when a poll budget runs out. A failed attempt ends with a reset command to the device, and the outcome is reported as a one-cycle done pulse with two error flags.

On the bus side the block has two request/acknowledge ports toward a transaction layer. The first is a command-write port carrying a word address and a 16-bit value. The second is a register-read port that returns a 16-bit status word. All addresses are word addresses. The byte address seen on a byte-addressed bus is the word address shifted left by one.

The pause between polls and the poll budget are both parameters. Their defaults, 2,500,000 cycles and 1000 polls, give roughly 10 ms spacing at 250 MHz.

Top module: `nor_sector_eraser`

## Requirements
- R1: After reset, busy, done, err_io, err_timeout, cmd_req and rd_req are all 0.
- R2: A start pulse while idle latches sector_addr, and busy is 1 from the next cycle through the cycle in which done is 1, then returns to 0. A start pulse while busy is ignored: the addresses used and the outcome stay those of the original request.
- R3: The erase chain consists of six writes, in this order. Writes 1 and 4 put 0x00AA at base+0x555. Writes 2 and 5 put 0x0055 at base+0x2AA. Write 3 puts 0x0080 at base+0x555. Write 6 puts 0x0030 at base. Address sums wrap modulo 2^ADDR_W.
- R4: cmd_req, and likewise rd_req, stays 1 with a constant address and data until the matching acknowledge is sampled high. The two requests are never high together.
- R5: Each status poll writes 0x0070 to base+0x555 and then reads from base.
- R6: A status word with bit 7 set and bits 4 and 5 clear ends the operation. done is 1 in the cycle after the read acknowledge, and both error flags are 0.
- R7: A status word with bit 7 set and bit 4 or bit 5 set causes a write of 0x00F0 to address 0. done then follows one cycle after that write's acknowledge, with err_io = 1.
- R8: A status word with bit 7 clear is treated as busy, whatever bits 4 and 5 hold. cmd_req for the next poll rises WAIT_CYCLES+1 cycles after the cycle in which the read acknowledge is high.
- R9: If POLL_MAX polls never show bit 7 set, the block writes 0x00F0 to address 0. done then follows with err_timeout = 1 and no further poll is made.
- R10: done lasts exactly one cycle. err_io and err_timeout are never 1 together, and are only 1 while done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an erase of the sector at sector_addr |
| sector_addr | input | ADDR_W | Sector base word address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_io | output | 1 | Device reported a program or erase failure (valid with done) |
| err_timeout | output | 1 | Poll budget exhausted (valid with done) |
| cmd_req | output | 1 | Command write request |
| cmd_addr | output | ADDR_W | Command write word address |
| cmd_data | output | 16 | Command write value |
| cmd_ack | input | 1 | Command write accepted |
| rd_req | output | 1 | Status read request |
| rd_addr | output | ADDR_W | Status read word address |
| rd_ack | input | 1 | Status read complete, rd_data valid |
| rd_data | input | 16 | Status word |

## Verification
Every transfer completes in the cycle after its acknowledge. As a result, done is due exactly one cycle after the last acknowledge, and the first poll write after a busy status is due WAIT_CYCLES+1 cycles after that read's acknowledge. The bench numbers each falling clock edge and records the edge at which each request first appears and each acknowledge is given. It then compares these edge numbers with those offsets, for every acknowledge latency in the sweep. Both the transfer log and the flags are compared against a sequence the bench rebuilds from the requirements for each combination of ready position and final status word.

// File: rtl/nor_sector_eraser.sv
module nor_sector_eraser #(
  parameter int ADDR_W      = 24,
  parameter int POLL_MAX    = 1000,
  parameter int WAIT_CYCLES = 2_500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] sector_addr,
  output logic              busy,
  output logic              done,
  output logic              err_io,
  output logic              err_timeout,
  output logic              cmd_req,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [15:0]       cmd_data,
  input  logic              cmd_ack,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [15:0]       rd_data
);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam int WW = $clog2(WAIT_CYCLES + 1);
  localparam logic [2:0] STEP_POLL = 3'd6;
  localparam logic [2:0] STEP_RST  = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_WAIT, S_FIN} st_t;

  st_t               st;
  logic [2:0]        step;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off;
  logic [PW-1:0]     polls;
  logic [WW-1:0]     wcnt;
  logic              f_io, f_to;
  logic              ready, bad, last_poll;

  always_comb begin
    case (step)
      3'd0:    begin off = ADDR_W'(12'h555); cmd_data = 16'h00AA; end
      3'd1:    begin off = ADDR_W'(12'h2AA); cmd_data = 16'h0055; end
      3'd2:    begin off = ADDR_W'(12'h555); cmd_data = 16'h0080; end
      3'd3:    begin off = ADDR_W'(12'h555); cmd_data = 16'h00AA; end
      3'd4:    begin off = ADDR_W'(12'h2AA); cmd_data = 16'h0055; end
      3'd5:    begin off = '0;               cmd_data = 16'h0030; end
      3'd6:    begin off = ADDR_W'(12'h555); cmd_data = 16'h0070; end
      default: begin off = '0;               cmd_data = 16'h00F0; end
    endcase
  end

  assign cmd_addr    = (step == STEP_RST) ? '0 : base + off;
  assign cmd_req     = (st == S_WR);
  assign rd_req      = (st == S_RD);
  assign rd_addr     = base;
  assign busy        = (st != S_IDLE);
  assign done        = (st == S_FIN);
  assign err_io      = done & f_io;
  assign err_timeout = done & f_to;
  assign ready       = rd_data[7];
  assign bad         = rd_data[4] | rd_data[5];
  assign last_poll   = (polls == PW'(POLL_MAX - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; step <= '0; base <= '0; polls <= '0;
      wcnt <= '0; f_io <= 1'b0; f_to <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          base <= sector_addr; step <= '0; polls <= '0;
          f_io <= 1'b0; f_to <= 1'b0; st <= S_WR;
        end
        S_WR: if (cmd_ack) begin
          if (step == STEP_RST)       st <= S_FIN;
          else if (step == STEP_POLL) st <= S_RD;
          else                        step <= step + 3'd1;
        end
        S_RD: if (rd_ack) begin
          polls <= polls + PW'(1);
          if (ready) begin
            if (bad) begin f_io <= 1'b1; step <= STEP_RST; st <= S_WR; end
            else st <= S_FIN;
          end else if (last_poll) begin
            f_to <= 1'b1; step <= STEP_RST; st <= S_WR;
          end else begin
            wcnt <= '0; st <= S_WAIT;
          end
        end
        S_WAIT:
          if (wcnt == WW'(WAIT_CYCLES - 1)) begin step <= STEP_POLL; st <= S_WR; end
          else wcnt <= wcnt + WW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_req && !rd_req && !done);
  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  assert_busy_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !cmd_ack |=> cmd_req && $stable(cmd_addr) && $stable(cmd_data));
  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
  assert_ports_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_req && rd_req));
  assert_poll_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> polls < PW'(POLL_MAX));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_io || err_timeout) |-> done && !(err_io && err_timeout));
endmodule

// File: tb/test_nor_sector_eraser.sv
module test_nor_sector_eraser;
  localparam int AW = 24;
  localparam int PM = 4;
  localparam int WC = 3;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] sector_addr = '0;
  logic busy, done, err_io, err_timeout, cmd_req, rd_req;
  logic [AW-1:0] cmd_addr, rd_addr;
  logic [15:0] cmd_data;
  logic cmd_ack = 0, rd_ack = 0;
  logic [15:0] rd_data = '0;

  always #2 clk = ~clk;

  nor_sector_eraser #(.ADDR_W(AW), .POLL_MAX(PM), .WAIT_CYCLES(WC)) i_nor_sector_eraser (
    .clk(clk), .rst_n(rst_n), .start(start), .sector_addr(sector_addr),
    .busy(busy), .done(done), .err_io(err_io), .err_timeout(err_timeout),
    .cmd_req(cmd_req), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_ack(cmd_ack),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data));

  int total = 0, bad = 0;
  int cyc = 0, lat = 0, ra = 0, pidx = 0, wc = 0, rc = 0;
  logic [15:0] fv = '0;
  bit wact = 0, in_op = 0, done_seen = 0, f_io = 0, f_to = 0;
  int wstart = 0, last_ack = 0, done_n = 0, nlog = 0;
  bit lk[64];
  logic [AW-1:0] la[64];
  logic [15:0] ld[64];
  int ln[64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (in_op && !done_seen && !busy) chk(0, "R2 busy low during op", 0, 1);
    if ((err_io || err_timeout) && !done) chk(0, "R10 flag without done", 1, 0);
    if (done) begin
      done_seen = 1; done_n = cyc; f_io = err_io; f_to = err_timeout;
    end
    if (cmd_ack) cmd_ack = 0;
    else if (cmd_req) begin
      if (!wact) begin wact = 1; wstart = cyc; wc = 0; end
      if (wc == lat) begin
        if (nlog < 64) begin lk[nlog] = 0; la[nlog] = cmd_addr; ld[nlog] = cmd_data; ln[nlog] = wstart; nlog++; end
        cmd_ack = 1; wact = 0; last_ack = cyc;
      end else wc++;
    end
    if (rd_ack) rd_ack = 0;
    else if (rd_req) begin
      if (rc == lat) begin
        rd_data = (pidx < ra) ? 16'h0030 : fv;
        pidx++;
        if (nlog < 64) begin lk[nlog] = 1; la[nlog] = rd_addr; ld[nlog] = rd_data; ln[nlog] = cyc; nlog++; end
        rd_ack = 1; rc = 0; last_ack = cyc;
      end else rc++;
    end
  end

  task automatic run_op(input logic [AW-1:0] b, input int lat_i, input int ra_i,
                        input logic [15:0] fv_i, input bit poke);
    bit ek[16];
    logic [AW-1:0] ea[16];
    logic [15:0] ed[16];
    int ne, np;
    bit to, io;
    lat = lat_i; ra = ra_i; fv = fv_i; pidx = 0; nlog = 0; done_seen = 0;
    @(negedge clk); sector_addr = b; start = 1;
    @(negedge clk); start = 0; in_op = 1;
    if (poke) begin
      repeat (3) @(negedge clk);
      sector_addr = b ^ 24'h00F0F0; start = 1;
      @(negedge clk); start = 0;
    end
    for (int g = 0; g < 2000 && !done_seen; g++) @(negedge clk);
    chk(done_seen, "R2 done reached", done_seen, 1);
    @(negedge clk); in_op = 0;
    chk(!busy, "R2 busy clear after done", busy, 0);
    chk(!done, "R10 done single cycle", done, 0);
    to = (ra >= PM);
    np = to ? PM : ra + 1;
    io = !to && (fv[4] || fv[5]);
    ne = 0;
    ek[ne] = 0; ea[ne] = b + AW'(12'h555); ed[ne] = 16'h00AA; ne++;
    ek[ne] = 0; ea[ne] = b + AW'(12'h2AA); ed[ne] = 16'h0055; ne++;
    ek[ne] = 0; ea[ne] = b + AW'(12'h555); ed[ne] = 16'h0080; ne++;
    ek[ne] = 0; ea[ne] = b + AW'(12'h555); ed[ne] = 16'h00AA; ne++;
    ek[ne] = 0; ea[ne] = b + AW'(12'h2AA); ed[ne] = 16'h0055; ne++;
    ek[ne] = 0; ea[ne] = b;                ed[ne] = 16'h0030; ne++;
    for (int p = 0; p < np; p++) begin
      ek[ne] = 0; ea[ne] = b + AW'(12'h555); ed[ne] = 16'h0070; ne++;
      ek[ne] = 1; ea[ne] = b; ed[ne] = (p < ra) ? 16'h0030 : fv; ne++;
    end
    if (to || io) begin ek[ne] = 0; ea[ne] = '0; ed[ne] = 16'h00F0; ne++; end
    chk(nlog == ne, to ? "R9 transfer count" : (io ? "R7 transfer count" : "R6 transfer count"), nlog, ne);
    for (int i = 0; i < ne && i < nlog; i++) begin
      string r;
      r = (i < 6) ? "R3 erase chain" : ((i == ne - 1 && (to || io)) ? "R7 reset write" : "R5 poll transfer");
      chk(lk[i] == ek[i] && la[i] == ea[i] && ld[i] == ed[i], r, {lk[i], la[i], ld[i]}, {ek[i], ea[i], ed[i]});
    end
    for (int i = 8; i < nlog; i++)
      if (lk[i] == 0 && ld[i] == 16'h0070 && lk[i-1] == 1)
        chk(ln[i] - ln[i-1] == WC + 1, "R8 poll spacing", ln[i] - ln[i-1], WC + 1);
    chk(done_n == last_ack + 1, "R6 done one cycle after last ack", done_n - last_ack, 1);
    chk(f_io == io, "R7 err_io", f_io, io);
    chk(f_to == to, "R9 err_timeout", f_to, to);
    chk(!(f_io && f_to), "R10 flags exclusive", {f_io, f_to}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] fvs[4];
    logic [AW-1:0] bases[4];
    fvs[0] = 16'h0080; fvs[1] = 16'h0090; fvs[2] = 16'h00A0; fvs[3] = 16'h00CF;
    bases[0] = '0; bases[1] = 24'h020000; bases[2] = 24'hFFFF00; bases[3] = 24'h5A5000;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err_io && !err_timeout && !cmd_req && !rd_req,
        "R1 reset state", {busy, done, err_io, err_timeout, cmd_req, rd_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !cmd_req && !rd_req, "R1 idle after release", {busy, cmd_req, rd_req}, 0);
    for (int l = 0; l < 2; l++)
      for (int r = 0; r <= PM; r++)
        for (int f = 0; f < 4; f++)
          run_op(bases[(l + r + f) % 4], l, r, fvs[f], 1'b0);
    run_op(24'h123400, 0, 1, 16'h0080, 1'b1);
    run_op(24'h003000, 2, 2, 16'h00B0, 1'b1);
    run_op(24'hFFFF00, 1, PM, 16'h0080, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule